// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames. A host writes a character into a one-entry holding register with a single-cycle strobe. When the serializer is idle, the character moves into the shift register on the next tick of the oversampling enable. The holding register is then free again, so the host can queue the following character while the current one is still being sent. With a character queued, each frame starts on the tick that ends the last stop bit of the previous frame, so there is no idle gap between frames.

Timing comes from a clock-enable `tick` that pulses at sixteen times the bit rate. Every serial bit lasts exactly sixteen ticks. Frame settings are captured from pins by a control-register strobe: data length of 5 to 8 bits, parity present or inhibited, parity sense, and one or two stop bits. Each frame takes the settings that are in force when it is transferred. A frame already in progress keeps its settings, and a later change applies from the next frame.

Top module: `dbuf_serial_tx`

## Requirements
- R1: The 2-bit `cfg_wlen` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. A parity bit is not counted in this number.
- R2: With `cfg_par_even` high, the parity bit makes the count of ones in the data bits plus the parity bit even. With it low, that count is odd. Parity is computed only over the selected data bits.
- R3: While reset is low, and after reset, `txd` is high and `hold_empty` and `shift_empty` are both high. The control register is cleared to all zero, which means 5 data bits, parity present and odd, and one stop bit. `txd` stays high whenever `shift_empty` is high.
- R4: A one-cycle `hold_load` captures `hold_data`, and `hold_empty` is low in the following cycle.
- R5: When the holding register is full and the shifter is idle, the transfer happens at the next clock edge where `tick` is high. At that same edge `txd` goes low for the start bit, `shift_empty` goes low and `hold_empty` goes high.
- R6: A frame is sent in this order: a low start bit, then the data bits least significant first, then the parity bit when enabled, then the stop bits, which are high.
- R7: Each serial bit lasts exactly 16 ticks. `txd` changes only at a clock edge where `tick` is high.
- R8: If a character is waiting when the last stop bit ends, its start bit begins on that same tick. When everything has been sent, `hold_empty` and `shift_empty` are both high.
- R9: Bits of `hold_data` above the selected length do not appear in the frame and do not affect the parity bit.
- R10: With `cfg_par_inhibit` high, the frame has no parity bit, and the stop bits follow the last data bit directly.
- R11: With `cfg_two_stop` low the frame has one stop bit. With it high the frame has two. `shift_empty` rises exactly 16 ticks after the start of the last stop bit.
- R12: `ctl_load` captures the settings. A capture made during a frame does not change that frame, and it applies to the next transferred character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Enable at 16 times the bit rate |
| ctl_load | input | 1 | Captures the cfg_* pins into the control register |
| cfg_wlen | input | 2 | Data length select (5 to 8 bits) |
| cfg_par_inhibit | input | 1 | Removes the parity bit from the frame |
| cfg_par_even | input | 1 | Parity sense: 1 for even, 0 for odd |
| cfg_two_stop | input | 1 | Stop bits: 0 for one, 1 for two |
| hold_load | input | 1 | Single-cycle strobe that writes hold_data into the holding register |
| hold_data | input | 8 | Character to send |
| txd | output | 1 | Serial output, high when idle |
| hold_empty | output | 1 | Holding register can accept a character |
| shift_empty | output | 1 | No frame is being sent |

## Verification
The serial output is decoded by sampling at the middle of each bit, for each of the four lengths. It is also decoded with all-zero and odd-weight data under both parity senses, which shows whether the sense or the covered range of bits is wrong. Data with ones only above a short length is compared against an all-zero frame, which exposes any leakage of unused bits. The time at which `shift_empty` rises separates one stop bit from two, and the start bit of the second of two queued characters must appear on the exact tick that ends the first frame. A settings change made in the middle of a frame checks that the frame in flight is not affected and that the next frame is.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DW     = 8;
  localparam int MIN_DW = 5;
  localparam int FW     = 1 + DW + 1 + 2;
  localparam int CNT_W  = $clog2(FW + 1);

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_inhibit;
    logic       par_even;
    logic       two_stop;
  } sertx_cfg_t;

  function automatic int data_bits(logic [1:0] wlen);
    return MIN_DW + int'(wlen);
  endfunction

  function automatic logic [DW-1:0] data_mask(logic [1:0] wlen);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < data_bits(wlen)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic parity_of(logic [DW-1:0] data, sertx_cfg_t cfg);
    logic p;
    p = ^(data & data_mask(cfg.wlen));
    return cfg.par_even ? p : ~p;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(sertx_cfg_t cfg);
    int n;
    n = 1 + data_bits(cfg.wlen) + (cfg.par_inhibit ? 0 : 1) + (cfg.two_stop ? 2 : 1);
    return CNT_W'(n);
  endfunction

  function automatic logic [FW-1:0] build_frame(logic [DW-1:0] data, sertx_cfg_t cfg);
    logic [FW-1:0] f;
    int nb;
    nb   = data_bits(cfg.wlen);
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < nb) f[1 + i] = data[i];
    end
    if (!cfg.par_inhibit) f[1 + nb] = parity_of(data, cfg);
    return f;
  endfunction

endpackage

// File: rtl/sertx_ctrl_reg.sv
module sertx_ctrl_reg
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  sertx_cfg_t cfg_in,
  output sertx_cfg_t cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end

endmodule

// File: rtl/sertx_hold_reg.sv
module sertx_hold_reg
  import sertx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] data_in,
  input  logic          take,
  output logic [DW-1:0] data_q,
  output logic          full
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full   <= 1'b0;
    end else begin
      if (load) data_q <= data_in;
      if (load)      full <= 1'b1;
      else if (take) full <= 1'b0;
    end
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  sertx_cfg_t    cfg,
  output logic          take,
  output logic          bit_end,
  output logic          frame_end,
  output logic          busy,
  output logic          txd
);

  localparam int SUB_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_BIT - 1);

  logic [FW-1:0]    sreg;
  logic [CNT_W-1:0] left;
  logic [SUB_W-1:0] sub;

  assign bit_end   = busy && tick && (sub == SUB_LAST);
  assign frame_end = bit_end && (left == CNT_W'(1));
  assign take      = tick && hold_full && (!busy || frame_end);
  assign txd       = sreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '1;
      left <= '0;
      sub  <= '0;
      busy <= 1'b0;
    end else if (take) begin
      sreg <= build_frame(hold_data, cfg);
      left <= frame_len(cfg);
      sub  <= '0;
      busy <= 1'b1;
    end else if (frame_end) begin
      sreg <= '1;
      left <= '0;
      sub  <= '0;
      busy <= 1'b0;
    end else if (bit_end) begin
      sreg <= {1'b1, sreg[FW-1:1]};
      left <= left - CNT_W'(1);
      sub  <= '0;
    end else if (busy && tick) begin
      sub  <= sub + SUB_W'(1);
    end
  end

endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ctl_load,
  input  logic [1:0]    cfg_wlen,
  input  logic          cfg_par_inhibit,
  input  logic          cfg_par_even,
  input  logic          cfg_two_stop,
  input  logic          hold_load,
  input  logic [DW-1:0] hold_data,
  output logic          txd,
  output logic          hold_empty,
  output logic          shift_empty
);

  sertx_cfg_t    cfg_pins;
  sertx_cfg_t    cfg_q;
  logic [DW-1:0] held;
  logic          hold_full;
  logic          xfer;
  logic          bit_end;
  logic          frame_end;
  logic          busy;

  assign cfg_pins = '{wlen: cfg_wlen, par_inhibit: cfg_par_inhibit,
                      par_even: cfg_par_even, two_stop: cfg_two_stop};

  sertx_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ctl_load),
    .cfg_in (cfg_pins),
    .cfg_q  (cfg_q)
  );

  sertx_hold_reg u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (hold_load),
    .data_in (hold_data),
    .take    (xfer),
    .data_q  (held),
    .full    (hold_full)
  );

  sertx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .hold_full (hold_full),
    .hold_data (held),
    .cfg       (cfg_q),
    .take      (xfer),
    .bit_end   (bit_end),
    .frame_end (frame_end),
    .busy      (busy),
    .txd       (txd)
  );

  assign hold_empty  = ~hold_full;
  assign shift_empty = ~busy;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic hold_load,
  input logic txd,
  input logic hold_empty,
  input logic shift_empty,
  input logic xfer,
  input logic bit_end,
  input logic frame_end
);

  AST_IDLE_IS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> txd); // R3

  AST_LOAD_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_load |=> !hold_empty); // R4

  AST_XFER_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold_empty && shift_empty) |-> xfer); // R5

  AST_XFER_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (!txd && !shift_empty)); // R5

  AST_XFER_FREES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !hold_load) |=> hold_empty); // R5

  AST_TXD_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd)); // R7

  AST_TXD_HELD_WITHIN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bit_end && !xfer) |=> $stable(txd)); // R7

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !hold_empty) |=> (!txd && !shift_empty)); // R8

  AST_END_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && hold_empty) |=> shift_empty); // R8

endmodule

bind dbuf_serial_tx sertx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .hold_load   (hold_load),
  .txd         (txd),
  .hold_empty  (hold_empty),
  .shift_empty (shift_empty),
  .xfer        (xfer),
  .bit_end     (bit_end),
  .frame_end   (frame_end)
);

// File: tb/dbuf_serial_tx_test.sv
`timescale 1ns/1ps
module dbuf_serial_tx_test;

  localparam int TDIV = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ctl_load = 1'b0;
  logic [1:0] cfg_wlen = 2'd0;
  logic       cfg_par_inhibit = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       hold_load = 1'b0;
  logic [7:0] hold_data = 8'h00;
  logic       txd, hold_empty, shift_empty;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic tick_at_edge = 1'b0;

  dbuf_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_load(ctl_load),
    .cfg_wlen(cfg_wlen), .cfg_par_inhibit(cfg_par_inhibit),
    .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
    .hold_load(hold_load), .hold_data(hold_data),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  always #2 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == TDIV - 1);
      c = (c == TDIV - 1) ? 0 : c + 1;
    end
  end

  always @(posedge clk) tick_at_edge <= tick;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench model of a frame: count of bits and the bits in send order.
  task automatic model_frame(input logic [7:0] d, input logic [1:0] w, input bit pinh,
                             input bit ev, input bit two, output logic [11:0] bits, output int n);
    int ones = 0;
    int nb = 5 + int'(w);
    bits = 12'hFFF;
    n = 0;
    bits[n] = 1'b0; n++;
    for (int i = 0; i < nb; i++) begin
      bits[n] = d[i]; n++;
      if (d[i]) ones++;
    end
    if (!pinh) begin
      bits[n] = ev ? ((ones % 2) == 1) : ((ones % 2) == 0);
      n++;
    end
    n += two ? 2 : 1;
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (tick) c++;
    end
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] w, input bit pinh, input bit ev, input bit two);
    cfg_wlen = w; cfg_par_inhibit = pinh; cfg_par_even = ev; cfg_two_stop = two;
    ctl_load = 1'b1;
    @(negedge clk);
    ctl_load = 1'b0;
  endtask

  task automatic load_char(input logic [7:0] d);
    hold_data = d;
    hold_load = 1'b1;
    @(negedge clk);
    hold_load = 1'b0;
    chk(hold_empty === 1'b0, "R4 hold_empty after load", 32'(hold_empty), 0);
  endtask

  task automatic wait_idle();
    while (!(shift_empty === 1'b1 && hold_empty === 1'b1)) @(negedge clk);
  endtask

  // Decodes one frame at bit centres and compares it with the model.
  task automatic rx_frame(input logic [7:0] d, input logic [1:0] w, input bit pinh,
                          input bit ev, input bit two, input bit idle_after, input string tag);
    logic [11:0] expb, got;
    int n;
    bit busy_ok = 1;
    model_frame(d, w, pinh, ev, two, expb, n);
    got = 12'hFFF;
    while (txd !== 1'b0) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      wait_ticks(i == 0 ? 8 : 16);
      got[i] = txd;
      if (shift_empty !== 1'b0) busy_ok = 0;
    end
    chk(got == expb, tag, 32'(got), 32'(expb));
    chk(busy_ok, {tag, " shift_empty low in frame"}, 32'(busy_ok), 1);
    if (idle_after) begin
      wait_ticks(8);
      chk(shift_empty === 1'b1 && hold_empty === 1'b1, {tag, " R8 R11 idle at frame end"},
          {30'd0, shift_empty, hold_empty}, 3);
    end
  endtask

  task automatic t_reset();
    chk(txd === 1'b1, "R3 txd in reset", 32'(txd), 1);
    chk(hold_empty === 1'b1 && shift_empty === 1'b1, "R3 flags in reset",
        {30'd0, hold_empty, shift_empty}, 3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && hold_empty === 1'b1 && shift_empty === 1'b1, "R3 after reset",
        {29'd0, txd, hold_empty, shift_empty}, 7);
  endtask

  task automatic t_defaults();
    load_char(8'hA6);
    rx_frame(8'hA6, 2'd0, 0, 0, 0, 1, "R3 cleared control gives 5 bits odd 1 stop");
  endtask

  task automatic t_load_flags();
    wait_idle();
    load_char(8'h3C);
    while (txd !== 1'b0) @(negedge clk);
    chk(tick_at_edge === 1'b1, "R5 transfer on tick edge", 32'(tick_at_edge), 1);
    chk(hold_empty === 1'b1 && shift_empty === 1'b0, "R5 flags at transfer",
        {30'd0, hold_empty, shift_empty}, 2);
    wait_idle();
  endtask

  task automatic t_word_lengths();
    for (int w = 0; w < 4; w++) begin
      set_cfg(2'(w), 0, 1, 0);
      load_char(8'hB5);
      rx_frame(8'hB5, 2'(w), 0, 1, 0, 1, "R1 R6 word length frame");
    end
  endtask

  task automatic t_parity();
    set_cfg(2'd3, 0, 1, 0);
    load_char(8'h00); rx_frame(8'h00, 2'd3, 0, 1, 0, 1, "R2 even parity zero data");
    load_char(8'h07); rx_frame(8'h07, 2'd3, 0, 1, 0, 1, "R2 even parity odd weight");
    set_cfg(2'd3, 0, 0, 0);
    load_char(8'h00); rx_frame(8'h00, 2'd3, 0, 0, 0, 1, "R2 odd parity zero data");
    load_char(8'h07); rx_frame(8'h07, 2'd3, 0, 0, 0, 1, "R2 odd parity odd weight");
  endtask

  task automatic t_upper_ignored();
    set_cfg(2'd0, 0, 1, 0);
    load_char(8'hE0);
    rx_frame(8'h00, 2'd0, 0, 1, 0, 1, "R9 upper bits ignored in 5-bit frame");
    set_cfg(2'd2, 0, 0, 0);
    load_char(8'h81);
    rx_frame(8'h01, 2'd2, 0, 0, 0, 1, "R9 bit 7 ignored in 7-bit frame");
  endtask

  task automatic t_inhibit();
    set_cfg(2'd1, 1, 1, 0);
    load_char(8'h2A);
    rx_frame(8'h2A, 2'd1, 1, 1, 0, 1, "R10 parity inhibited");
  endtask

  task automatic t_stops();
    set_cfg(2'd3, 1, 0, 1);
    load_char(8'h5A);
    rx_frame(8'h5A, 2'd3, 1, 0, 1, 1, "R11 two stop bits");
    set_cfg(2'd3, 1, 0, 0);
    load_char(8'h5A);
    rx_frame(8'h5A, 2'd3, 1, 0, 0, 1, "R11 one stop bit");
  endtask

  task automatic t_bit_time();
    int c = 0;
    set_cfg(2'd3, 0, 1, 0);
    load_char(8'h01);
    while (txd !== 1'b0) @(negedge clk);
    while (txd === 1'b0) begin
      @(posedge clk);
      if (tick) c++;
      @(negedge clk);
    end
    chk(c == 16, "R7 start bit lasts 16 ticks", 32'(c), 16);
    wait_idle();
  endtask

  task automatic t_back_to_back();
    set_cfg(2'd2, 0, 1, 0);
    load_char(8'h4D);
    while (hold_empty !== 1'b1) @(negedge clk);
    load_char(8'h32);
    rx_frame(8'h4D, 2'd2, 0, 1, 0, 0, "R8 first of pair");
    wait_ticks(8);
    chk(txd === 1'b0 && shift_empty === 1'b0 && hold_empty === 1'b1,
        "R8 next start bit without gap", {29'd0, txd, shift_empty, hold_empty}, 1);
    rx_frame(8'h32, 2'd2, 0, 1, 0, 1, "R8 second of pair");
  endtask

  task automatic t_ctrl_midframe();
    set_cfg(2'd3, 0, 1, 1);
    load_char(8'hC3);
    while (shift_empty !== 1'b0) @(negedge clk);
    set_cfg(2'd0, 1, 0, 0);
    rx_frame(8'hC3, 2'd3, 0, 1, 1, 1, "R12 frame in flight keeps settings");
    load_char(8'hC3);
    rx_frame(8'hC3, 2'd0, 1, 0, 0, 1, "R12 next frame uses new settings");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_defaults();
    t_load_flags();
    t_word_lengths();
    t_parity();
    t_upper_ignored();
    t_inhibit();
    t_stops();
    t_bit_time();
    t_back_to_back();
    t_ctrl_midframe();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule